// File: doc/BRIEF.md
# Floating-Point Multiplier with Shared Double-Precision Datapath

This block multiplies two IEEE-754 numbers. A precision select picks the format. In double mode each operand is a full 64-bit word. In single mode only the low 32 bits of each operand are used, and they are widened to double before any arithmetic. From that point one datapath serves both formats:

- The sign is the XOR of the two operand signs.
- The exponents are added and one bias is removed.
- The two 53-bit significands are multiplied by a tree of carry-save compressors.
- The product is post-normalized, a guard bit and a sticky bit are formed, and the result is rounded to the width of the selected format.

A single-precision result is returned in the low 32 bits with the upper half cleared. Five exception flags come with every result.

Operation is a start/done handshake with a fixed latency. A controller has four states:

- `S_IDLE` accepts `start` and captures the operands, the precision and the rounding mode.
- `S_MUL` registers the significand product together with the sign, exponent and special-case class.
- `S_RND` normalizes, rounds and packs, and registers the result.
- `S_DONE` raises `done` for one cycle.

The controller always moves IDLE→MUL on an accepted start, then MUL→RND, RND→DONE and DONE→IDLE. Each of these three moves takes one cycle and has no condition. A `start` seen outside `S_IDLE` is ignored. Subnormal inputs are treated as zero. Results below the normal range are flushed to a signed zero.

Top module: `fpm_mul`

## Requirements
- R1: A `start` sampled high in idle makes `done` high for exactly one cycle, in the third cycle after the accepting edge. A `start` sampled while busy (including the `done` cycle) is ignored.
- R2: The result sign is the XOR of the operand signs. This holds for finite, infinite and zero results.
- R3: In double mode (`dbl`=1), a product of normal operands has the exponent ea+eb−1023, plus one when the significand product is at least 2. The significand is correctly rounded from the exact product.
- R4: In single mode (`dbl`=0), only `op_a[31:0]` and `op_b[31:0]` are read. The result is rounded to single precision and placed in `result[31:0]`, with `result[63:32]`=0.
- R5: `rmode` selects the rounding: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward −infinity.
- R6: The inexact flag `flags[0]` is set when any discarded product bit is non-zero.
- R7: A NaN operand, or infinity times zero, gives a positive quiet NaN and sets only invalid (`flags[4]`). The NaN is 0x7FF8000000000000 in double mode and 0x7FC00000 in single mode.
- R8: Infinity times a non-zero value gives a signed infinity, and zero times a finite value gives a signed zero. Neither case raises a flag.
- R9: When the rounded exponent reaches the all-ones code, `flags[2]` (overflow) and `flags[0]` are set. The result is infinity under nearest-even, and under a directed mode that rounds away from zero for that sign. Otherwise it is the largest finite value of that sign.
- R10: When the normalized exponent before rounding falls below 1, the result is a signed zero and `flags[1]` (underflow) and `flags[0]` are set.
- R11: A subnormal operand (exponent field 0) behaves as a zero of its sign.
- R12: The divide-by-zero flag `flags[3]` is always 0.
- R13: After reset, `done`, `result` and `flags` are 0. `result` and `flags` change only at the edge that raises `done`, and hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; sampled only in idle |
| dbl | input | 1 | 1 = double precision, 0 = single precision |
| rmode | input | 2 | Rounding mode code |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| done | output | 1 | One-cycle pulse when result and flags are valid |
| result | output | 64 | Product; single results in bits 31:0 |
| flags | output | 5 | {invalid, divzero, overflow, underflow, inexact} |

## Verification
A controller stuck in a state, or one that skips a state, shows at the ports as a missing, doubled or misplaced `done` pulse. It is therefore seen within four cycles of a start. A wrong staged sign, exponent or class bit, or a bad compressor column, appears in `result` or `flags` at the very next `done` pulse. The bench compares that pulse against a behavioural model that finds the leading one and rounds by comparing the remainder with one half. Rounding-direction errors show only in the last significand bit or in the overflow saturation value, so the directed cases target exact halves, one-ulp carries and all four modes at the exponent limit.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int FW      = 52;
    localparam int EW      = 11;
    localparam int SW      = FW + 1;
    localparam int PW      = 2 * SW;
    localparam int XW      = EW + 3;
    localparam int BIAS    = (1 << (EW - 1)) - 1;
    localparam int EMAX    = (1 << EW) - 1;
    localparam int SFW     = 23;
    localparam int SEW     = 8;
    localparam int SBIAS   = (1 << (SEW - 1)) - 1;
    localparam int SEMAX   = (1 << SEW) - 1;
    localparam int GAP     = BIAS - SBIAS;
    localparam int NFLG    = 5;

    localparam int FL_INV  = 4;
    localparam int FL_DZ   = 3;
    localparam int FL_OVF  = 2;
    localparam int FL_UDF  = 1;
    localparam int FL_INX  = 0;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_POS  = 2'b10,
        RM_NEG  = 2'b11
    } fpm_rm_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MUL,
        S_RND,
        S_DONE
    } fpm_state_e;

    typedef struct packed {
        logic          sign;
        logic [EW-1:0] exp;
        logic [SW-1:0] sig;
        logic          zero;
        logic          inf;
        logic          nan;
    } fpm_opnd_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [63:0] raw,
    input  logic        dbl,
    output fpm_opnd_t   o
);
    logic [EW-1:0] e;
    logic [FW-1:0] f;
    logic          e_max;

    always_comb begin
        if (dbl) begin
            o.sign = raw[63];
            e      = raw[62:52];
            f      = raw[51:0];
            e_max  = &raw[62:52];
        end else begin
            o.sign = raw[31];
            f      = {raw[22:0], {(FW-SFW){1'b0}}};
            e_max  = &raw[30:23];
            if (raw[30:23] == '0)
                e = '0;
            else if (e_max)
                e = EW'(EMAX);
            else
                e = EW'(raw[30:23]) + EW'(GAP);
        end
        o.zero = (e == '0);
        o.inf  = e_max && (f == '0);
        o.nan  = e_max && (f != '0);
        o.exp  = e;
        o.sig  = {~o.zero, f};
    end
endmodule

// File: rtl/fpm_csa_tree.sv
module fpm_csa_tree #(
    parameter int N = 53,
    localparam int W = 2 * N,
    localparam int ROWS = 3 * N - 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [W-1:0] p
);
    always_comb begin
        logic [W-1:0] w [ROWS];
        logic [W-1:0] x, y, z;
        for (int i = 0; i < ROWS; i++)
            w[i] = '0;
        for (int i = 0; i < N; i++)
            w[i] = b[i] ? (W'(a) << i) : '0;
        for (int s = 0; s < N - 2; s++) begin
            x = w[3*s];
            y = w[3*s+1];
            z = w[3*s+2];
            w[N+2*s]   = x ^ y ^ z;
            w[N+2*s+1] = ((x & y) | (x & z) | (y & z)) << 1;
        end
        p = w[3*N-6] + w[3*N-5];
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  logic                 sign,
    input  logic signed [XW-1:0] exp_in,
    input  logic [PW-1:0]        prod,
    input  logic                 dbl,
    input  fpm_rm_e              rm,
    input  logic                 is_nan,
    input  logic                 is_inf,
    input  logic                 is_zero,
    output logic [63:0]          res,
    output logic [NFLG-1:0]      flg
);
    logic [PW-1:0]        norm;
    logic signed [XW-1:0] e1, eb, ef, emax;
    logic [SW-1:0]        keep;
    logic [SW:0]          sum;
    logic                 g, st, inc, carry, to_inf;
    logic [FW-1:0]        frac;

    always_comb begin
        norm = prod[PW-1] ? prod : (prod << 1);
        e1   = exp_in + $signed({{(XW-1){1'b0}}, prod[PW-1]});
        if (dbl) begin
            keep = norm[PW-1:PW-SW];
            g    = norm[PW-SW-1];
            st   = |norm[PW-SW-2:0];
            eb   = e1;
            emax = XW'(EMAX);
        end else begin
            keep = {{(SW-SFW-1){1'b0}}, norm[PW-1:PW-SFW-1]};
            g    = norm[PW-SFW-2];
            st   = |norm[PW-SFW-3:0];
            eb   = e1 - XW'(GAP);
            emax = XW'(SEMAX);
        end
        unique case (rm)
            RM_NEAR: inc = g & (st | keep[0]);
            RM_ZERO: inc = 1'b0;
            RM_POS:  inc = ~sign & (g | st);
            RM_NEG:  inc = sign & (g | st);
        endcase
        sum   = {1'b0, keep} + {{SW{1'b0}}, inc};
        carry = dbl ? sum[SW] : sum[SFW+1];
        ef    = eb + $signed({{(XW-1){1'b0}}, carry});
        if (dbl)
            frac = carry ? sum[SW-1:1] : sum[FW-1:0];
        else
            frac = {{(FW-SFW){1'b0}}, carry ? sum[SFW:1] : sum[SFW-1:0]};
        to_inf = (rm == RM_NEAR) || (rm == RM_POS && !sign) || (rm == RM_NEG && sign);

        flg = '0;
        if (is_nan) begin
            res = dbl ? {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}}
                      : {32'b0, 1'b0, {SEW{1'b1}}, 1'b1, {(SFW-1){1'b0}}};
            flg[FL_INV] = 1'b1;
        end else if (is_inf) begin
            res = dbl ? {sign, {EW{1'b1}}, {FW{1'b0}}}
                      : {32'b0, sign, {SEW{1'b1}}, {SFW{1'b0}}};
        end else if (is_zero) begin
            res = dbl ? {sign, 63'b0} : {32'b0, sign, 31'b0};
        end else if (eb < XW'(1)) begin
            res = dbl ? {sign, 63'b0} : {32'b0, sign, 31'b0};
            flg[FL_UDF] = 1'b1;
            flg[FL_INX] = 1'b1;
        end else if (ef >= emax) begin
            if (dbl)
                res = to_inf ? {sign, {EW{1'b1}}, {FW{1'b0}}}
                             : {sign, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
            else
                res = to_inf ? {32'b0, sign, {SEW{1'b1}}, {SFW{1'b0}}}
                             : {32'b0, sign, {(SEW-1){1'b1}}, 1'b0, {SFW{1'b1}}};
            flg[FL_OVF] = 1'b1;
            flg[FL_INX] = 1'b1;
        end else begin
            res = dbl ? {sign, ef[EW-1:0], frac}
                      : {32'b0, sign, ef[SEW-1:0], frac[SFW-1:0]};
            flg[FL_INX] = g | st;
        end
    end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
    import fpm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            dbl,
    input  logic [1:0]      rmode,
    input  logic [63:0]     op_a,
    input  logic [63:0]     op_b,
    output logic            done,
    output logic [63:0]     result,
    output logic [NFLG-1:0] flags
);
    fpm_state_e           state_q, state_d;
    logic [1:0][63:0]     ops_q;
    logic                 dbl_q;
    fpm_rm_e              rm_q;
    fpm_opnd_t            unp [2];
    logic [PW-1:0]        prod_w, prod_q;
    logic                 sign_q, nan_q, inf_q, zero_q;
    logic signed [XW-1:0] exp_q;
    logic [63:0]          res_w;
    logic [NFLG-1:0]      flg_w;

    for (genvar gi = 0; gi < 2; gi++) begin : g_unp
        fpm_unpack u_unp (.raw(ops_q[gi]), .dbl(dbl_q), .o(unp[gi]));
    end

    fpm_csa_tree #(.N(SW)) u_tree (.a(unp[0].sig), .b(unp[1].sig), .p(prod_w));

    fpm_round u_rnd (
        .sign(sign_q), .exp_in(exp_q), .prod(prod_q), .dbl(dbl_q), .rm(rm_q),
        .is_nan(nan_q), .is_inf(inf_q), .is_zero(zero_q), .res(res_w), .flg(flg_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_MUL;
            S_MUL:  state_d = S_RND;
            S_RND:  state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ops_q  <= '0;
            dbl_q  <= 1'b1;
            rm_q   <= RM_NEAR;
            prod_q <= '0;
            sign_q <= 1'b0;
            exp_q  <= '0;
            nan_q  <= 1'b0;
            inf_q  <= 1'b0;
            zero_q <= 1'b0;
            result <= '0;
            flags  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    ops_q <= {op_b, op_a};
                    dbl_q <= dbl;
                    rm_q  <= fpm_rm_e'(rmode);
                end
                S_MUL: begin
                    prod_q <= prod_w;
                    sign_q <= unp[0].sign ^ unp[1].sign;
                    exp_q  <= $signed({3'b0, unp[0].exp}) + $signed({3'b0, unp[1].exp})
                              - XW'(BIAS);
                    nan_q  <= unp[0].nan | unp[1].nan | (unp[0].inf & unp[1].zero)
                              | (unp[0].zero & unp[1].inf);
                    inf_q  <= unp[0].inf | unp[1].inf;
                    zero_q <= unp[0].zero | unp[1].zero;
                end
                S_RND: begin
                    result <= res_w;
                    flags  <= flg_w;
                end
                S_DONE: ;
            endcase
        end
    end

    assign done = (state_q == S_DONE);
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        done,
    input logic [63:0] result,
    input logic [4:0]  flags,
    input logic        dbl_q
);
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 3));

    p_sp_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dbl_q) |-> (result[63:32] == 32'b0));

    p_ovf_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[2]) |-> (flags[0] && !flags[1] && !flags[4]));

    p_udf_inexact_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[1]) |-> (flags[0] && result[62:0] == 63'b0));

    p_divzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flags[3] == 1'b0);

    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> ($stable(result) && $stable(flags)));
endmodule

bind fpm_mul fpm_mul_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .result(result), .flags(flags), .dbl_q(dbl_q)
);

// File: tb/fpm_mul_tb_top.sv
`timescale 1ns/1ps
module fpm_mul_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dbl = 1'b1;
    logic [1:0]  rmode = 2'b00;
    logic [63:0] op_a = '0, op_b = '0;
    logic        done;
    logic [63:0] result;
    logic [4:0]  flags;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    string cur_tag = "R13";

    int          mcnt = 0;
    logic [68:0] mpend = '0;
    logic [63:0] mres = '0;
    logic [4:0]  mflg = '0;
    string       ptag = "R13", rtag = "R13";

    always #10 clk = ~clk;

    fpm_mul dut_i (.clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl), .rmode(rmode),
        .op_a(op_a), .op_b(op_b), .done(done), .result(result), .flags(flags));

    function automatic logic [63:0] pk(bit s, int ex, logic [63:0] fr, bit dp);
        int hi = dp ? 63 : 31;
        int fb = dp ? 52 : 23;
        return (64'(s) << hi) | (64'(ex) << fb) | fr;
    endfunction

    function automatic logic [68:0] ref_mul(logic [63:0] a, logic [63:0] b, bit dp,
                                            logic [1:0] rm);
        int fb = dp ? 52 : 23;
        int emx = dp ? 2047 : 255;
        int bias = dp ? 1023 : 127;
        int hi = dp ? 63 : 31;
        logic [63:0] fmask = (64'd1 << fb) - 64'd1;
        logic [63:0] qn = dp ? 64'h7FF8000000000000 : 64'h0000_0000_7FC0_0000;
        logic [127:0] ma, mb, p, m, rem, half;
        int ea, eb, L, sh, ex;
        bit s, na, nb, ia, ib, za, zb, inc, found, up;
        ea = int'((a >> fb) & 64'(emx));
        eb = int'((b >> fb) & 64'(emx));
        s = a[hi] ^ b[hi];
        na = (ea == emx) && ((a & fmask) != 0);
        nb = (eb == emx) && ((b & fmask) != 0);
        ia = (ea == emx) && ((a & fmask) == 0);
        ib = (eb == emx) && ((b & fmask) == 0);
        za = (ea == 0);
        zb = (eb == 0);
        if (na || nb || (ia && zb) || (za && ib)) return {5'b10000, qn};
        if (ia || ib) return {5'b00000, pk(s, emx, 64'd0, dp)};
        if (za || zb) return {5'b00000, pk(s, 0, 64'd0, dp)};
        ma = 128'(a & fmask) | (128'd1 << fb);
        mb = 128'(b & fmask) | (128'd1 << fb);
        p = ma * mb;
        L = 0; found = 0;
        for (int i = 127; i >= 0; i--)
            if (!found && p[i]) begin L = i; found = 1; end
        ex = ea + eb - bias + (L - 2 * fb);
        sh = L - fb;
        m = p >> sh;
        rem = p & ((128'd1 << sh) - 128'd1);
        half = 128'd1 << (sh - 1);
        case (rm)
            2'b00: inc = (rem > half) || (rem == half && m[0]);
            2'b01: inc = 0;
            2'b10: inc = !s && rem != 0;
            default: inc = s && rem != 0;
        endcase
        if (ex < 1) return {5'b00011, pk(s, 0, 64'd0, dp)};
        if (inc) m = m + 128'd1;
        if (m == (128'd1 << (fb + 1))) begin m = m >> 1; ex++; end
        if (ex >= emx) begin
            up = (rm == 2'b00) || (rm == 2'b10 && !s) || (rm == 2'b11 && s);
            return {5'b00101, up ? pk(s, emx, 64'd0, dp) : pk(s, emx - 1, fmask, dp)};
        end
        return {4'b0000, rem != 0, pk(s, ex, 64'(m) & fmask, dp)};
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // cycle model: accept in idle, done three edges later
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt = 0; mres = '0; mflg = '0;
        end else begin
            if (mcnt == 0 && start) begin
                mpend = ref_mul(op_a, op_b, dbl, rmode);
                ptag = cur_tag;
                mcnt = 3;
            end else if (mcnt > 0) begin
                mcnt--;
                if (mcnt == 1) begin
                    mres = mpend[63:0]; mflg = mpend[68:64]; rtag = ptag;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1", "done", 64'(done), 64'(mcnt == 1));
            chk(rtag, "result", result, mres);
            chk(rtag, "flags", 64'(flags), 64'(mflg));
            chk("R12", "divzero", 64'(flags[3]), 64'd0);
        end
    end

    task automatic op(logic [63:0] a, logic [63:0] b, bit dp, logic [1:0] rm, string tag);
        @(negedge clk);
        op_a = a; op_b = b; dbl = dp; rmode = rm; cur_tag = tag; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic kop(logic [63:0] a, logic [63:0] b, bit dp, logic [1:0] rm, string tag,
                       logic [63:0] er, logic [4:0] ef);
        op(a, b, dp, rm, tag);
        chk(tag, "known result", result, er);
        chk(tag, "known flags", 64'(flags), 64'(ef));
    endtask

    function automatic logic [63:0] rnd_opnd(bit dp);
        int r = int'($urandom_range(0, 99));
        int emx = dp ? 2047 : 255;
        int bias = dp ? 1023 : 127;
        int e;
        logic [63:0] fr = dp ? ({$urandom, $urandom} & 64'h000F_FFFF_FFFF_FFFF)
                             : 64'($urandom & 32'h007F_FFFF);
        bit s = 1'($urandom);
        if (r < 4)       e = 0;
        else if (r < 7)  e = emx;
        else if (r < 17) e = int'($urandom_range(0, 1)) ? emx - 1 - int'($urandom_range(0, 3))
                                                        : 1 + int'($urandom_range(0, 3));
        else             e = bias - 60 + int'($urandom_range(0, 120));
        if (r == 5) fr = 64'd0;
        return dp ? pk(s, e, fr, 1) : ({$urandom, 32'd0} | pk(s, e, fr, 0));
    endfunction

    initial begin
        #3_000_000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", "reset done", 64'(done), 64'd0);
        chk("R13", "reset result", result, 64'd0);
        chk("R13", "reset flags", 64'(flags), 64'd0);
        rst_n = 1'b1;
        kop(64'h3FF8000000000000, 64'h4000000000000000, 1, 2'b00, "R3", 64'h4008000000000000, 5'b00000);
        kop(64'hBFF8000000000000, 64'h4000000000000000, 1, 2'b00, "R2", 64'hC008000000000000, 5'b00000);
        kop(64'hBFF8000000000000, 64'hC000000000000000, 1, 2'b01, "R2", 64'h4008000000000000, 5'b00000);
        kop(64'h3FF0000000000001, 64'h3FF0000000000001, 1, 2'b00, "R5 R6", 64'h3FF0000000000002, 5'b00001);
        kop(64'h3FF0000000000001, 64'h3FF0000000000001, 1, 2'b10, "R5", 64'h3FF0000000000003, 5'b00001);
        kop(64'h3FF0000000000001, 64'h3FF0000000000001, 1, 2'b01, "R5", 64'h3FF0000000000002, 5'b00001);
        kop(64'hBFF0000000000001, 64'h3FF0000000000001, 1, 2'b11, "R5", 64'hBFF0000000000003, 5'b00001);
        kop(64'h7FF0000000000001, 64'h3FF0000000000000, 1, 2'b00, "R7", 64'h7FF8000000000000, 5'b10000);
        kop(64'hFFF0000000000000, 64'h0000000000000000, 1, 2'b00, "R7", 64'h7FF8000000000000, 5'b10000);
        kop(64'hFFF0000000000000, 64'h4000000000000000, 1, 2'b00, "R8", 64'hFFF0000000000000, 5'b00000);
        kop(64'h8000000000000000, 64'h4000000000000000, 1, 2'b00, "R8", 64'h8000000000000000, 5'b00000);
        kop(64'h0000000000000001, 64'h3FF0000000000000, 1, 2'b00, "R11", 64'h0000000000000000, 5'b00000);
        kop(64'h800FFFFFFFFFFFFF, 64'h3FF0000000000000, 1, 2'b00, "R11", 64'h8000000000000000, 5'b00000);
        kop(64'h7FE0000000000000, 64'h4000000000000000, 1, 2'b00, "R9", 64'h7FF0000000000000, 5'b00101);
        kop(64'h7FE0000000000000, 64'h4000000000000000, 1, 2'b01, "R9", 64'h7FEFFFFFFFFFFFFF, 5'b00101);
        kop(64'h7FE0000000000000, 64'h4000000000000000, 1, 2'b11, "R9", 64'h7FEFFFFFFFFFFFFF, 5'b00101);
        kop(64'hFFE0000000000000, 64'h4000000000000000, 1, 2'b11, "R9", 64'hFFF0000000000000, 5'b00101);
        kop(64'hFFE0000000000000, 64'h4000000000000000, 1, 2'b10, "R9", 64'hFFEFFFFFFFFFFFFF, 5'b00101);
        kop(64'h0010000000000000, 64'h3FE0000000000000, 1, 2'b00, "R10", 64'h0000000000000000, 5'b00011);
        kop(64'h8010000000000000, 64'h3FE0000000000000, 1, 2'b10, "R10", 64'h8000000000000000, 5'b00011);
        kop(64'hDEADBEEF3FC00000, 64'h1234567840000000, 0, 2'b00, "R4", 64'h0000000040400000, 5'b00000);
        kop(64'hFFFFFFFF3F800001, 64'h000000003F800001, 0, 2'b00, "R4", 64'h000000003F800002, 5'b00001);
        kop(64'hFFFFFFFF3F800001, 64'h000000003F800001, 0, 2'b10, "R4", 64'h000000003F800003, 5'b00001);
        kop(64'h000000007F000000, 64'hAAAAAAAA40000000, 0, 2'b00, "R4 R9", 64'h000000007F800000, 5'b00101);
        kop(64'h000000007FC00000, 64'h000000003F800000, 0, 2'b00, "R4 R7", 64'h000000007FC00000, 5'b10000);
        kop(64'h0000000000800000, 64'h000000003F000000, 0, 2'b00, "R4 R10", 64'h0000000000000000, 5'b00011);
        // start held high: accepted every fourth edge, ignored while busy
        @(negedge clk);
        op_a = 64'h4000000000000000; op_b = 64'h4008000000000000; dbl = 1; rmode = 2'b00;
        cur_tag = "R1"; start = 1'b1;
        repeat (11) @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        for (int k = 0; k < 400; k++) begin
            bit dp = 1'($urandom);
            logic [63:0] a = rnd_opnd(dp);
            logic [63:0] b = rnd_opnd(dp);
            op(a, b, dp, 2'($urandom), dp ? "R3 R5" : "R4 R5");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule